// File: doc/BRIEF.md
# Write-FIFO / Read-Latch Bus Buffer

This block is an 18-bit two-way buffer that links a fast bus on side A with a slower agent on side B. Traffic from A to B goes through a four-word synchronous FIFO. A single clock drives the FIFO, and separate active-low enables request a push and a pop. An active-low flag reports when the FIFO is full. The FIFO also has a synchronous active-low clear. Its B-side output is a registered word, and only a pop that is performed updates it.

Traffic from B to A goes through a level-sensitive latch. While the latch enable is high, B data flows straight to A. When the enable falls, the latch keeps the value it holds. Each side has its own active-low output enable. The pads are modelled as a data-out bus plus an active-high drive signal, so a pad ring can build the tri-state buffer outside this block.

Top module: `rw_bus_buffer`

## Requirements
- R1: On a rising clock edge with `wr_en_n` low and the FIFO not full, `a_in` is stored. On a rising edge with `rd_en_n` low and the FIFO not empty, `b_out` takes the oldest stored word. Words leave in the order they were stored, and `b_out` is valid from that same edge.
- R2: The FIFO holds exactly four words. `full_n` is low after the edge that makes four words stored and high at every other occupancy (0 to 3).
- R3: A push requested while the FIFO is full is dropped. The stored words and their order are unchanged.
- R4: A pop requested while the FIFO is empty has no effect: `b_out` keeps the last word popped (or all ones after a clear).
- R5: `fifo_rst_n` low at a rising edge empties the FIFO, sets `b_out` to all ones and sets `full_n` high. It takes priority over a push or pop in the same cycle.
- R6: A push and a pop in the same cycle, with the FIFO neither empty nor full, are both performed. The occupancy and `full_n` stay the same.
- R7: A push and a pop together on an empty FIFO perform only the push (`b_out` unchanged, one word stored). Together on a full FIFO they perform only the pop (`b_out` takes the head word, three words remain, the pushed word is lost).
- R8: While `latch_en` is high, `a_out` equals `b_in`.
- R9: On the falling edge of `latch_en`, the latch captures `b_in`. `a_out` then holds that value while `latch_en` stays low, whatever `b_in` does.
- R10: `b_drive` is the inverse of `oe_b_n` and `a_drive` is the inverse of `oe_a_n`. Neither output enable changes any data or FIFO state.
- R11: The FIFO path and the latch path are independent. Latch activity does not change `b_out` or `full_n`, and FIFO activity does not change `a_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock, rising edge |
| fifo_rst_n | input | 1 | Synchronous FIFO clear, active low |
| wr_en_n | input | 1 | Push request, active low |
| rd_en_n | input | 1 | Pop request, active low |
| a_in | input | 18 | Word from side A into the FIFO |
| b_out | output | 18 | Registered FIFO output toward side B |
| b_drive | output | 1 | Side-B pad drive enable, active high |
| full_n | output | 1 | FIFO full flag, low when four words are stored |
| oe_b_n | input | 1 | Side-B output enable, active low |
| b_in | input | 18 | Word from side B into the latch |
| latch_en | input | 1 | Latch transparent when high, holds when low |
| a_out | output | 18 | Latch output toward side A |
| a_drive | output | 1 | Side-A pad drive enable, active high |
| oe_a_n | input | 1 | Side-A output enable, active low |

## Verification
The bench targets the two boundary collisions. At the empty boundary, a design that performed the pop would put a stale memory word on `b_out`. At the full boundary, a design that performed the push would overwrite the head word or leave `full_n` low. It also pushes past four words and pops past empty. A wrong design here would drop the flag late, corrupt the order of the stored words, or lose the held output word. A clear is applied while both enables are active; if the clear lost priority, a word would stay in the FIFO or `b_out` would not be all ones. The latch is checked for capture on the falling edge and for holding while B changes, and it is exercised alongside FIFO traffic so that any coupling between the two paths shows up.

// File: rtl/rwbuf_pkg.sv
package rwbuf_pkg;

    parameter int unsigned DATA_W = 18;
    parameter int unsigned DEPTH  = 4;

    typedef struct packed {
        logic push;
        logic pop;
    } fifo_op_t;

    function automatic int unsigned idx_next(int unsigned idx, int unsigned depth);
        return (idx + 1 == depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rwbuf_wfifo.sv
module rwbuf_wfifo
    import rwbuf_pkg::*;
#(
    parameter int unsigned DATA_W = rwbuf_pkg::DATA_W,
    parameter int unsigned DEPTH  = rwbuf_pkg::DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              push_req,
    input  logic              pop_req,
    output logic [DATA_W-1:0] dout,
    output logic              full_n
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [CNT_W-1:0]  level, level_nx;
    logic              empty, full;
    fifo_op_t          op;

    assign empty   = (level == '0);
    assign full    = (level == LVL_FULL);
    // Boundary resolution: full blocks the push, empty blocks the pop.
    assign op.push = push_req && !full;
    assign op.pop  = pop_req && !empty;

    always_comb begin
        level_nx = level;
        case ({op.push, op.pop})
            2'b10:   level_nx = level + 1'b1;
            2'b01:   level_nx = level - 1'b1;
            default: level_nx = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (op.push && rst_n) begin
            mem[wr_idx] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
            dout   <= '1;
            full_n <= 1'b1;
        end else begin
            if (op.push) begin
                wr_idx <= PTR_W'(idx_next(int'(wr_idx), DEPTH));
            end
            if (op.pop) begin
                dout   <= mem[rd_idx];
                rd_idx <= PTR_W'(idx_next(int'(rd_idx), DEPTH));
            end
            level  <= level_nx;
            full_n <= (level_nx != LVL_FULL);
        end
    end

    // R2: the registered flag agrees with the occupancy counter
    a_r2_flag_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        full_n == (level != LVL_FULL));

    // R3: a push into a full FIFO without a pop leaves the write index alone
    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> ($stable(wr_idx) && !full_n));

    // R4: a pop on an empty FIFO leaves the output word unchanged
    a_r4_hold_on_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req) |=> $stable(dout));

    // R5: a clear always leaves an empty FIFO with all-ones output
    a_r5_clear_state: assert property (@(posedge clk)
        !rst_n |=> (dout == '1 && full_n && level == '0));

    // R7: a collision on an empty FIFO performs only the push
    a_r7_empty_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && push_req && pop_req) |=> ($stable(dout) && level == 1));

endmodule

// File: rtl/rwbuf_rdlatch.sv
module rwbuf_rdlatch #(
    parameter int unsigned DATA_W = rwbuf_pkg::DATA_W
) (
    input  logic              le,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_latch begin
        if (le) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rw_bus_buffer.sv
module rw_bus_buffer
    import rwbuf_pkg::*;
#(
    parameter int unsigned DATA_W = rwbuf_pkg::DATA_W,
    parameter int unsigned DEPTH  = rwbuf_pkg::DEPTH
) (
    input  logic              clk,
    input  logic              fifo_rst_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive,
    output logic              full_n,
    input  logic              oe_b_n,
    input  logic [DATA_W-1:0] b_in,
    input  logic              latch_en,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic              oe_a_n
);
    rwbuf_wfifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wfifo (
        .clk      (clk),
        .rst_n    (fifo_rst_n),
        .din      (a_in),
        .push_req (!wr_en_n),
        .pop_req  (!rd_en_n),
        .dout     (b_out),
        .full_n   (full_n)
    );

    rwbuf_rdlatch #(.DATA_W(DATA_W)) u_rdlatch (
        .le (latch_en),
        .d  (b_in),
        .q  (a_out)
    );

    assign b_drive = !oe_b_n;
    assign a_drive = !oe_a_n;

    // R8: transparent phase follows side B
    a_r8_transparent: assert property (@(posedge clk)
        latch_en |-> (a_out == b_in));

    // R9: closed latch keeps its word between samples
    a_r9_hold_closed: assert property (@(posedge clk) disable iff (!fifo_rst_n)
        (!latch_en && !$past(latch_en)) |-> $stable(a_out));

endmodule

// File: tb/rw_bus_buffer_tb.sv
module rw_bus_buffer_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         fifo_rst_n = 1'b0;
    logic         wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         oe_b_n = 1'b1, oe_a_n = 1'b1, latch_en = 1'b0;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive, full_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] model_q[$];
    logic [W-1:0] exp_b = '1;

    rw_bus_buffer u_dut (
        .clk(clk), .fifo_rst_n(fifo_rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .a_in(a_in), .b_out(b_out), .b_drive(b_drive), .full_n(full_n),
        .oe_b_n(oe_b_n), .b_in(b_in), .latch_en(latch_en), .a_out(a_out),
        .a_drive(a_drive), .oe_a_n(oe_a_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of FIFO traffic; called at a falling edge, returns at the next.
    task automatic step(input bit w, input bit r, input logic [W-1:0] d, input string req);
        bit mt, fl;
        wr_en_n = !w; rd_en_n = !r; a_in = d;
        mt = (model_q.size() == 0);
        fl = (model_q.size() == 4);
        if (r && !mt) exp_b = model_q.pop_front();
        if (w && !fl) model_q.push_back(d);
        @(posedge clk);
        @(negedge clk);
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        chk(req, 32'(b_out), 32'(exp_b));
        chk(req, 32'(full_n), 32'(model_q.size() != 4));
    endtask

    task automatic clear(input bit w, input bit r);
        fifo_rst_n = 1'b0; wr_en_n = !w; rd_en_n = !r; a_in = 18'h2AAAA;
        @(posedge clk);
        @(negedge clk);
        fifo_rst_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        model_q.delete();
        exp_b = '1;
        chk("R5 clear output", 32'(b_out), 32'h3FFFF);
        chk("R5 clear flag", 32'(full_n), 32'd1);
    endtask

    task automatic t_reset_state;
        clear(1'b0, 1'b0);
        step(1'b0, 1'b1, '0, "R4 pop after clear");
    endtask

    task automatic t_fill_and_overflow;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, 18'h01000 + 18'(i), "R2 fill");
        end
        chk("R2 full at four", 32'(full_n), 32'd0);
        step(1'b1, 1'b0, 18'h3DEAD, "R3 push while full");
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, '0, "R1 ordered drain");
        end
        chk("R1 last word", 32'(b_out), 32'h01003);
        step(1'b0, 1'b1, '0, "R4 pop past empty");
        step(1'b0, 1'b1, '0, "R4 pop past empty again");
    endtask

    task automatic t_mid_collision;
        step(1'b1, 1'b0, 18'h00AA1, "R1 push");
        step(1'b1, 1'b0, 18'h00AA2, "R1 push");
        step(1'b1, 1'b1, 18'h00AA3, "R6 push and pop");
        step(1'b1, 1'b1, 18'h00AA4, "R6 push and pop");
        step(1'b0, 1'b1, '0, "R6 drain");
        step(1'b0, 1'b1, '0, "R6 drain");
        step(1'b0, 1'b1, '0, "R4 empty after drain");
    endtask

    task automatic t_empty_collision;
        logic [W-1:0] held;
        held = exp_b;
        step(1'b1, 1'b1, 18'h15151, "R7 empty collision");
        chk("R7 empty output held", 32'(b_out), 32'(held));
        step(1'b0, 1'b1, '0, "R7 word stored");
        chk("R7 stored word", 32'(b_out), 32'h15151);
    endtask

    task automatic t_full_collision;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, 18'h02000 + 18'(i), "R2 refill");
        end
        step(1'b1, 1'b1, 18'h3BEEF, "R7 full collision");
        chk("R7 full pops head", 32'(b_out), 32'h02000);
        chk("R7 full flag released", 32'(full_n), 32'd1);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, '0, "R7 pushed word lost");
        end
        chk("R7 final word", 32'(b_out), 32'h02003);
    endtask

    task automatic t_clear_priority;
        step(1'b1, 1'b0, 18'h0C0C0, "R1 push");
        step(1'b1, 1'b0, 18'h0C0C1, "R1 push");
        clear(1'b1, 1'b1);
        step(1'b0, 1'b1, '0, "R5 nothing left after clear");
        step(1'b1, 1'b0, 18'h07777, "R5 push after clear");
        step(1'b0, 1'b1, '0, "R5 first word after clear");
    endtask

    task automatic t_latch;
        latch_en = 1'b1; b_in = 18'h12345;
        #3 chk("R8 transparent", 32'(a_out), 32'h12345);
        b_in = 18'h2ABCD;
        #3 chk("R8 follows", 32'(a_out), 32'h2ABCD);
        @(negedge clk);
        latch_en = 1'b0;
        #3 b_in = 18'h00F0F;
        #3 chk("R9 captured", 32'(a_out), 32'h2ABCD);
        step(1'b1, 1'b0, 18'h33333, "R11 fifo while latch closed");
        chk("R11 latch unaffected", 32'(a_out), 32'h2ABCD);
        b_in = 18'h3FFFE;
        step(1'b0, 1'b1, '0, "R11 pop while latch closed");
        chk("R9 still held", 32'(a_out), 32'h2ABCD);
        latch_en = 1'b1;
        #3 chk("R8 reopen", 32'(a_out), 32'h3FFFE);
        chk("R11 fifo unaffected by latch", 32'(b_out), 32'(exp_b));
        @(negedge clk);
        latch_en = 1'b0;
        #3 b_in = 18'h00001;
        #3 chk("R9 second capture", 32'(a_out), 32'h3FFFE);
    endtask

    task automatic t_out_enables;
        logic [W-1:0] b_before, a_before;
        b_before = b_out; a_before = a_out;
        for (int k = 0; k < 4; k++) begin
            oe_b_n = k[0]; oe_a_n = k[1];
            #2;
            chk("R10 b drive", 32'(b_drive), 32'(!k[0]));
            chk("R10 a drive", 32'(a_drive), 32'(!k[1]));
        end
        chk("R10 data untouched b", 32'(b_out), 32'(b_before));
        chk("R10 data untouched a", 32'(a_out), 32'(a_before));
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_fill_and_overflow();
        t_mid_collision();
        t_empty_collision();
        t_full_collision();
        t_clear_priority();
        t_latch();
        @(negedge clk);
        t_out_enables();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule